// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block produces the modulated carrier for an infrared remote-control transmitter. It drives an open-drain, high-current pin. The pin is represented here by a drive-enable and a data level. A three-bit mode register selects one of seven carrier shapes, each a fixed period and high time in oscillator cycles. An eighth mode turns the pin into a plain software-controlled level with no pulse train.

The surrounding core controls the block with three strobes that carry its index register value. A mode load takes the low three bits of that value. An output-set strobe turns the carrier on and an output-clear strobe releases the pin, but each acts only when the index value selects this pin. A stop input models the halted-oscillator state. While stop is high the pin floats and every piece of state is frozen. When stop is released the pin resumes exactly where it left off.

Every accepted enable and every accepted mode load restarts the period from its first cycle. The first pulse after either is therefore a complete high phase.

Top module: `ir_carrier_gen`

## Requirements
- R1: After a cycle with `rst_n` low, `pad_oe_o` and `pad_lvl_o` are 0, the output latch is off and the mode is 0.
- R2: In mode 0 with the carrier on, `pad_lvl_o` repeats a 96-cycle period that is high for its first 48 cycles and low for the rest.
- R3: Mode 1 gives a 96-cycle period with 32 high cycles. Mode 6 gives 96 cycles with 24 high.
- R4: Mode 2 gives a 64-cycle period with 32 high cycles. Mode 3 gives 64 cycles with 16 high.
- R5: Mode 4 gives an 88-cycle period with 32 high cycles. Mode 7 gives 92 cycles with 46 high.
- R6: In mode 5 with the output latch on, the pin is driven (`pad_oe_o`=1) at a constant `pad_lvl_o`=1 with no toggling.
- R7: A `set_i` strobe with `y_i`=8 turns the output latch on, and a `clr_i` strobe with `y_i`=8 turns it off (`pad_oe_o`=0). Set or clear strobes with any other `y_i` value have no effect.
- R8: When accepted set and clear strobes arrive in the same cycle, clear wins and the latch ends off.
- R9: `load_i` stores `y_i[2:0]` as the new mode and ignores `y_i[3]`. An accepted load, or an accepted set, restarts the period, so the next cycle is the first cycle of a full high phase.
- R10: While `stop_i` is 1, `pad_oe_o` is 0, and loads and strobes are ignored. Latch, mode and phase are held, and after release the waveform continues from the held phase.
- R11: `pad_lvl_o` is 0 whenever `pad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_i | input | 1 | Stop mode: pin floats, state frozen |
| load_i | input | 1 | Load mode register from `y_i[2:0]` |
| set_i | input | 1 | Output-set strobe, acts when `y_i`=8 |
| clr_i | input | 1 | Output-clear strobe, acts when `y_i`=8 |
| y_i | input | 4 | Index register value accompanying the strobes |
| pad_oe_o | output | 1 | Pin drive enable (0 = high impedance) |
| pad_lvl_o | output | 1 | Pin data level while driven |

## Verification
Two groups of operations can coincide in one cycle. The first is a mode load or enable strobe landing in the same cycle as a stop request. The second is a set strobe arriving together with a clear strobe. The bench drives each of these pairings on purpose, including a load followed at once by a set and a load issued while stopped. A behavioural model applies the stated priorities (stop blocks everything, clear beats set) and its predicted pin state is compared with the block on every cycle. Separate measurements of high-run length and period after each restart confirm that the first pulse is a full high phase for all seven carrier shapes.

// File: rtl/ircg_pkg.sv
// Package: shared types and the carrier shape table.
// Assumes periods fit in CNT_W bits; mode STATIC_MODE carries no pulse train.
package ircg_pkg;

    localparam int MODE_W = 3;
    localparam int CNT_W  = 7;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam mode_t STATIC_MODE = mode_t'(5);

    typedef struct packed {
        cnt_t period;
        cnt_t high;
    } shape_t;

    // Returns period and high time, in oscillator cycles, for a mode.
    function automatic shape_t mode_shape(input mode_t m);
        shape_t s;
        case (m)
            mode_t'(0): s = '{period: cnt_t'(96), high: cnt_t'(48)};
            mode_t'(1): s = '{period: cnt_t'(96), high: cnt_t'(32)};
            mode_t'(2): s = '{period: cnt_t'(64), high: cnt_t'(32)};
            mode_t'(3): s = '{period: cnt_t'(64), high: cnt_t'(16)};
            mode_t'(4): s = '{period: cnt_t'(88), high: cnt_t'(32)};
            mode_t'(6): s = '{period: cnt_t'(96), high: cnt_t'(24)};
            mode_t'(7): s = '{period: cnt_t'(92), high: cnt_t'(46)};
            default:    s = '{period: cnt_t'(1),  high: cnt_t'(1)};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ircg_ctrl.sv
// Control: holds the mode register and the output latch, and flags
// the cycles that must restart the period.
// Assumes strobes are single-cycle; stop blocks every update.
module ircg_ctrl
    import ircg_pkg::*;
#(
    parameter int Y_W      = 4,
    parameter int SEL_CODE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stop_i,
    input  logic           load_i,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic [Y_W-1:0] y_i,
    output mode_t          mode_o,
    output logic           en_o,
    output logic           restart_o
);

    localparam logic [Y_W-1:0] SEL_VAL = Y_W'(SEL_CODE);

    logic  sel_hit;
    logic  acc_set, acc_clr, acc_load;
    mode_t mode_q;
    logic  en_q;

    // Qualify the strobes: this pin selected and the core awake.
    always_comb begin
        sel_hit   = (y_i == SEL_VAL);
        acc_set   = !stop_i && set_i && sel_hit;
        acc_clr   = !stop_i && clr_i && sel_hit;
        acc_load  = !stop_i && load_i;
        restart_o = (acc_set && !acc_clr) || acc_load;
    end

    // Mode register: low bits of the index value on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= '0;
        else if (acc_load) mode_q <= y_i[MODE_W-1:0];
    end

    // Output latch: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (acc_clr) en_q <= 1'b0;
        else if (acc_set) en_q <= 1'b1;
    end

    assign mode_o = mode_q;
    assign en_o   = en_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && set_i && clr_i && sel_hit) |=> !en_q); // R8

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ($stable(mode_q) && $stable(en_q))); // R10

endmodule

// File: rtl/ircg_phase.sv
// Phase counter: counts oscillator cycles within the carrier period.
// Assumes period_i >= 1 and stable except at a restart.
module ircg_phase
    import ircg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic restart_i,
    input  logic run_i,
    input  cnt_t period_i,
    output cnt_t cnt_o
);

    cnt_t cnt_q;
    logic at_end;

    // Last cycle of the current period.
    always_comb at_end = (cnt_q == period_i - cnt_t'(1));

    // Restart wins, stop freezes, idle parks at zero, else wrap-count.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (stop_i)    cnt_q <= cnt_q;
        else if (!run_i)    cnt_q <= '0;
        else if (at_end)    cnt_q <= '0;
        else                cnt_q <= cnt_q + cnt_t'(1);
    end

    assign cnt_o = cnt_q;

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < period_i)); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/ircg_wave.sv
// Wave shaper: turns latch, mode and phase into pin enable and level.
// Assumes the phase stays below the period of the current mode.
module ircg_wave
    import ircg_pkg::*;
(
    input  mode_t mode_i,
    input  logic  en_i,
    input  logic  stop_i,
    input  cnt_t  cnt_i,
    input  cnt_t  high_i,
    output logic  oe_o,
    output logic  lvl_o
);

    logic is_static;
    logic in_high;

    // Drive while latched and awake; high phase or static level.
    always_comb begin
        is_static = (mode_i == STATIC_MODE);
        in_high   = (cnt_i < high_i);
        oe_o      = en_i && !stop_i;
        lvl_o     = oe_o && (is_static || in_high);
    end

endmodule

// File: rtl/ir_carrier_gen.sv
// Top: programmable IR carrier generator with stop handling.
// Assumes one clock per oscillator cycle and a synchronous active-low reset.
module ir_carrier_gen
    import ircg_pkg::*;
#(
    parameter int Y_W      = 4,
    parameter int SEL_CODE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stop_i,
    input  logic           load_i,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic [Y_W-1:0] y_i,
    output logic           pad_oe_o,
    output logic           pad_lvl_o
);

    mode_t  mode_w;
    logic   en_w, restart_w, run_w;
    shape_t shape_w;
    cnt_t   cnt_w;

    ircg_ctrl #(.Y_W(Y_W), .SEL_CODE(SEL_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .load_i(load_i),
        .set_i(set_i), .clr_i(clr_i), .y_i(y_i),
        .mode_o(mode_w), .en_o(en_w), .restart_o(restart_w)
    );

    // Shape lookup and run qualifier for the counter.
    always_comb begin
        shape_w = mode_shape(mode_w);
        run_w   = en_w && (mode_w != STATIC_MODE);
    end

    ircg_phase u_phase (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .restart_i(restart_w),
        .run_i(run_w), .period_i(shape_w.period), .cnt_o(cnt_w)
    );

    ircg_wave u_wave (
        .mode_i(mode_w), .en_i(en_w), .stop_i(stop_i), .cnt_i(cnt_w),
        .high_i(shape_w.high), .oe_o(pad_oe_o), .lvl_o(pad_lvl_o)
    );

    AST_STOP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !pad_oe_o); // R10

    AST_FIRST_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        restart_w |=> (!pad_oe_o || pad_lvl_o)); // R9

    AST_FLOAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe_o |-> !pad_lvl_o); // R11

endmodule

// File: tb/ir_carrier_gen_tb_top.sv
module ir_carrier_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_i = 1'b0, load_i = 1'b0, set_i = 1'b0, clr_i = 1'b0;
    logic [3:0] y_i = 4'd0;
    logic       pad_oe_o, pad_lvl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_en = 0, m_mode = 0, m_cnt = 0;

    ir_carrier_gen dut_i (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .load_i(load_i),
        .set_i(set_i), .clr_i(clr_i), .y_i(y_i),
        .pad_oe_o(pad_oe_o), .pad_lvl_o(pad_lvl_o)
    );

    always #4 clk = ~clk;

    function automatic int per_of(int m);
        case (m)
            0: return 96; 1: return 96; 2: return 64; 3: return 64;
            4: return 88; 6: return 96; 7: return 92; default: return 1;
        endcase
    endfunction

    function automatic int hi_of(int m);
        case (m)
            0: return 48; 1: return 32; 2: return 32; 3: return 16;
            4: return 32; 6: return 24; 7: return 46; default: return 1;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge from the held inputs.
    always @(posedge clk) begin
        int nen, nmode, ncnt;
        bit aset, aclr, restart;
        nen = m_en; nmode = m_mode; ncnt = m_cnt;
        if (!rst_n) begin
            nen = 0; nmode = 0; ncnt = 0;
        end else if (!stop_i) begin
            aset = set_i && (y_i == 4'd8);
            aclr = clr_i && (y_i == 4'd8);
            if (aclr) nen = 0; else if (aset) nen = 1;
            if (load_i) nmode = int'(y_i) % 8;
            restart = (aset && !aclr) || load_i;
            if (restart) ncnt = 0;
            else if (m_en == 0 || m_mode == 5) ncnt = 0;
            else ncnt = (m_cnt + 1) % per_of(m_mode);
        end
        m_en <= nen; m_mode <= nmode; m_cnt <= ncnt;
    end

    // Cycle compare, 2 ns after each rising edge.
    always @(posedge clk) begin
        int eoe, elvl;
        string tag;
        #2;
        if (rst_n) begin
            eoe  = (m_en != 0 && !stop_i) ? 1 : 0;
            elvl = (eoe == 1 && (m_mode == 5 || m_cnt < hi_of(m_mode))) ? 1 : 0;
            if (stop_i) tag = "R10";
            else if (m_en == 0) tag = "R11";
            else if (m_mode == 5) tag = "R6";
            else tag = "R9";
            check(tag, int'(pad_oe_o), eoe);
            check(tag, int'(pad_lvl_o), elvl);
        end
    end

    task automatic idle_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(bit ld, bit st, bit cl, logic [3:0] y);
        @(negedge clk);
        load_i = ld; set_i = st; clr_i = cl; y_i = y;
        @(negedge clk);
        load_i = 0; set_i = 0; clr_i = 0; y_i = 4'd0;
    endtask

    // Enable mode m, then measure high-run and period from the restart.
    task automatic measure(int m, string req);
        int highs, first, at_p;
        pulse(1, 0, 0, 4'(m));
        @(negedge clk); set_i = 1; y_i = 4'd8;
        highs = 0;
        @(posedge clk); #2; first = pad_lvl_o;
        if (pad_lvl_o) highs++;
        @(negedge clk); set_i = 0; y_i = 4'd0;
        for (int i = 1; i < per_of(m); i++) begin
            @(posedge clk); #2;
            if (pad_lvl_o) highs++;
        end
        @(posedge clk); #2; at_p = pad_lvl_o;
        check(req, first, 1);
        check(req, highs, hi_of(m));
        check(req, at_p, 1);
        pulse(0, 0, 1, 4'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #2;
        check("R1", int'(pad_oe_o), 0);       // R1 reset state
        check("R1", int'(pad_lvl_o), 0);
        pulse(0, 1, 0, 4'd8);                 // mode 0 default from reset
        idle_cyc(2);
        @(posedge clk); #3;
        check("R1", int'(pad_lvl_o), 1);
        pulse(0, 0, 1, 4'd8);

        measure(0, "R2");
        measure(1, "R3");
        measure(6, "R3");
        measure(2, "R4");
        measure(3, "R4");
        measure(4, "R5");
        measure(7, "R5");
        measure(12, "R9");                    // y[3] ignored: acts as mode 4

        // R6 static mode.
        pulse(1, 0, 0, 4'd5);
        pulse(0, 1, 0, 4'd8);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #3;
            check("R6", int'(pad_lvl_o), 1);
        end
        pulse(0, 0, 1, 4'd8);

        // R7 strobes with wrong index ignored.
        pulse(1, 0, 0, 4'd0);
        pulse(0, 1, 0, 4'd9);
        idle_cyc(3);
        check("R7", int'(pad_oe_o), 0);
        pulse(0, 1, 0, 4'd8);
        pulse(0, 0, 1, 4'd0);
        idle_cyc(3);
        check("R7", int'(pad_oe_o), 1);
        pulse(0, 0, 1, 4'd8);
        idle_cyc(1);
        check("R7", int'(pad_oe_o), 0);

        // R8 set and clear together.
        pulse(0, 1, 1, 4'd8);
        idle_cyc(2);
        check("R8", int'(pad_oe_o), 0);

        // R9 load mid-period restarts the phase.
        pulse(0, 1, 0, 4'd8);
        idle_cyc(60);
        pulse(1, 0, 0, 4'd3);
        idle_cyc(120);
        pulse(0, 0, 1, 4'd8);

        // R10 stop: freeze, ignore strobes and loads, resume.
        pulse(1, 0, 0, 4'd2);
        pulse(0, 1, 0, 4'd8);
        idle_cyc(20);
        @(negedge clk); stop_i = 1;
        idle_cyc(5);
        check("R10", int'(pad_oe_o), 0);
        @(negedge clk); load_i = 1; set_i = 0; clr_i = 1; y_i = 4'd8;
        @(negedge clk); load_i = 0; clr_i = 0; y_i = 4'd0;
        idle_cyc(5);
        stop_i = 0;
        idle_cyc(80);
        check("R10", int'(pad_oe_o), 1);
        // Stop raised in the same cycle as a set: set ignored.
        pulse(0, 0, 1, 4'd8);
        @(negedge clk); stop_i = 1; set_i = 1; y_i = 4'd8;
        @(negedge clk); stop_i = 0; set_i = 0; y_i = 4'd0;
        idle_cyc(2);
        check("R10", int'(pad_oe_o), 0);
        // Load then set on consecutive cycles, and reset mid-run.
        @(negedge clk); load_i = 1; y_i = 4'd7;
        @(negedge clk); load_i = 0; set_i = 1; y_i = 4'd8;
        @(negedge clk); set_i = 0; y_i = 4'd0;
        idle_cyc(100);
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R1", int'(pad_oe_o), 0);
        check("R11", int'(pad_lvl_o), 0);
        idle_cyc(3);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule